// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block sits in the fetch stage and turns the current fetch address into the address of the next fetch. Each fetch address is looked up in a small direct-mapped table of branch targets. When a valid entry with a matching tag is found, its stored target is sent on as the next fetch address and a hit flag is raised. When nothing is found, fetch falls through to the sequential address, which amounts to predicting not-taken.

The back end resolves branches and reports them on an update port: the branch address, its target, whether it was taken and whether its target lies below its own address. How the table reacts depends on an allocation policy fixed at elaboration. In loop-only mode, only taken branches flagged as backward are written, so loop-closing branches are predicted taken from then on. In last-outcome mode, every taken branch is written and a not-taken result removes the matching entry, so each branch is predicted as it last went.

Top module: `btb_pred`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until an update has been applied.
- R2: On a miss, pred_hit is 0 and next_pc equals fetch_pc + 1, wrapping modulo 2^PC_W.
- R3: On a hit (fetch_valid high, entry valid and stored tag equal to the upper fetch_pc bits), pred_hit is 1 and next_pc equals the stored target.
- R4: In last-outcome mode, a taken update installs its target at its index, whatever the backward flag says.
- R5: In last-outcome mode, a not-taken update clears the entry at its index only when the stored tag matches its address; an entry owned by another address stays as it is.
- R6: In loop-only mode, a taken update installs an entry only when upd_backward is 1; a taken forward update changes nothing, not even an entry at the same index.
- R7: In loop-only mode, not-taken updates change nothing.
- R8: The table index is fetch_pc[IDX_W-1:0] and the tag is the remaining upper bits. An install replaces whatever the index held, so the previous owner then misses.
- R9: A lookup in the same cycle as an update to the same index sees the old contents. The new contents are visible from the next cycle on.
- R10: With fetch_valid low, pred_hit is 0 and next_pc is fetch_pc + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch lookup is requested this cycle |
| fetch_pc | input | PC_W | Fetch address being looked up |
| next_pc | output | PC_W | Predicted next fetch address |
| pred_hit | output | 1 | A valid matching entry supplied next_pc |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_target | input | PC_W | Resolved target address |
| upd_taken | input | 1 | The branch was taken |
| upd_backward | input | 1 | The target lies below the branch address |

## Verification
Two instances, one per policy, receive identical update streams. After each stage of the stream, the bench sweeps every fetch address of an 8-bit configuration. The updates pair taken and not-taken results with backward and forward flags, so the sweeps separate the two allocation rules. Further updates alias two addresses onto one index, which exposes an index or tag taken from the wrong bits and a clear that ignores the tag. The sweep also covers the top address to catch a sequential address that does not wrap. A same-cycle lookup and write to one index checks that the stored contents change only at the clock edge, and a lookup with fetch_valid low checks that the hit is gated.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Allocation policy chosen at elaboration
    typedef enum logic {
        POL_BACKWARD = 1'b0,   // keep taken backward branches only
        POL_LAST     = 1'b1    // keep the last outcome of every branch
    } btb_policy_e;

    // Write operation applied to one table entry
    typedef enum logic [1:0] {
        WR_NONE    = 2'd0,
        WR_INSTALL = 2'd1,
        WR_CLEAR   = 2'd2
    } btb_wr_e;

endpackage

// File: rtl/btb_index_split.sv
module btb_index_split #(
    parameter int PC_W  = 16,
    parameter int IDX_W = 4
) (
    input  logic [PC_W-1:0]      pc,
    output logic [IDX_W-1:0]     idx,
    output logic [PC_W-IDX_W-1:0] tag
);
    // Low bits pick the entry, the rest are compared as the tag
    assign idx = pc[IDX_W-1:0];
    assign tag = pc[PC_W-1:IDX_W];
endmodule

// File: rtl/btb_alloc_ctrl.sv
module btb_alloc_ctrl
    import btb_pkg::*;
#(
    parameter btb_policy_e POLICY = POL_LAST
) (
    input  logic    upd_valid,
    input  logic    upd_taken,
    input  logic    upd_backward,
    input  logic    tag_match,
    output btb_wr_e wr_op
);
    btb_wr_e op_last;
    btb_wr_e op_loop;

    always_comb begin
        op_last = WR_NONE;
        if (upd_valid) begin
            if (upd_taken) begin
                op_last = WR_INSTALL;
            end else if (tag_match) begin
                op_last = WR_CLEAR;
            end
        end
    end

    always_comb begin
        op_loop = WR_NONE;
        if (upd_valid && upd_taken && upd_backward) begin
            op_loop = WR_INSTALL;
        end
    end

    assign wr_op = (POLICY == POL_LAST) ? op_last : op_loop;
endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic                   rd_valid,
    output logic [PC_W-IDX_W-1:0]  rd_tag,
    output logic [PC_W-1:0]        rd_target,
    input  logic [IDX_W-1:0]       cmp_idx,
    output logic                   cmp_valid,
    output logic [PC_W-IDX_W-1:0]  cmp_tag,
    input  btb_wr_e                wr_op,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [PC_W-IDX_W-1:0]  wr_tag,
    input  logic [PC_W-1:0]        wr_target
);
    localparam int TAG_W = PC_W - IDX_W;
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  target;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
    } store_t;

    store_t st_d;
    store_t st_q;
    entry_t ent_nxt [DEPTH];

    // Per-entry next value
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        always_comb begin
            ent_nxt[gi] = st_q.ent[gi];
            if (wr_idx == IDX_W'(gi)) begin
                case (wr_op)
                    WR_INSTALL: begin
                        ent_nxt[gi].valid  = 1'b1;
                        ent_nxt[gi].tag    = wr_tag;
                        ent_nxt[gi].target = wr_target;
                    end
                    WR_CLEAR: ent_nxt[gi].valid = 1'b0;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            st_d.ent[i] = ent_nxt[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Fetch-side read port
    assign rd_valid  = st_q.ent[rd_idx].valid;
    assign rd_tag    = st_q.ent[rd_idx].tag;
    assign rd_target = st_q.ent[rd_idx].target;

    // Update-side read port for tag matching before a clear
    assign cmp_valid = st_q.ent[cmp_idx].valid;
    assign cmp_tag   = st_q.ent[cmp_idx].tag;
endmodule

// File: rtl/btb_pred.sv
module btb_pred
    import btb_pkg::*;
#(
    parameter int          PC_W   = 16,
    parameter int          IDX_W  = 4,
    parameter btb_policy_e POLICY = POL_LAST
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] next_pc,
    output logic            pred_hit,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_taken,
    input  logic            upd_backward
);
    localparam int TAG_W = PC_W - IDX_W;

    typedef struct packed {
        logic            hit;
        logic [PC_W-1:0] npc;
    } pred_t;

    logic [IDX_W-1:0] f_idx;
    logic [TAG_W-1:0] f_tag;
    logic [IDX_W-1:0] u_idx;
    logic [TAG_W-1:0] u_tag;
    logic             rd_valid;
    logic [TAG_W-1:0] rd_tag;
    logic [PC_W-1:0]  rd_target;
    logic             cmp_valid;
    logic [TAG_W-1:0] cmp_tag;
    logic             u_match;
    btb_wr_e          wr_op;
    pred_t            pred_d;

    btb_index_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fetch_split (
        .pc  (fetch_pc),
        .idx (f_idx),
        .tag (f_tag)
    );

    btb_index_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_upd_split (
        .pc  (upd_pc),
        .idx (u_idx),
        .tag (u_tag)
    );

    assign u_match = cmp_valid && (cmp_tag == u_tag);

    btb_alloc_ctrl #(.POLICY(POLICY)) u_alloc (
        .upd_valid    (upd_valid),
        .upd_taken    (upd_taken),
        .upd_backward (upd_backward),
        .tag_match    (u_match),
        .wr_op        (wr_op)
    );

    btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (f_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_target (rd_target),
        .cmp_idx   (u_idx),
        .cmp_valid (cmp_valid),
        .cmp_tag   (cmp_tag),
        .wr_op     (wr_op),
        .wr_idx    (u_idx),
        .wr_tag    (u_tag),
        .wr_target (upd_target)
    );

    // Next fetch address: stored target on a hit, sequential otherwise
    always_comb begin
        pred_d.hit = fetch_valid && rd_valid && (rd_tag == f_tag);
        pred_d.npc = pred_d.hit ? rd_target : (fetch_pc + PC_W'(1));
    end

    assign pred_hit = pred_d.hit;
    assign next_pc  = pred_d.npc;
endmodule

// File: rtl/btb_pred_chk.sv
module btb_pred_chk #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_valid,
    input logic [PC_W-1:0] fetch_pc,
    input logic [PC_W-1:0] next_pc,
    input logic            pred_hit,
    input logic            upd_valid
);
    logic wr_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_seen_q <= 1'b0;
        end else if (upd_valid) begin
            wr_seen_q <= 1'b1;
        end
    end

    // R1: nothing can hit before an update has been clocked in
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_seen_q |-> !pred_hit);

    // R2: a miss falls through to the sequential address
    p_miss_sequential_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (next_pc == fetch_pc + PC_W'(1)));

    // R9: without a write in the previous cycle, a repeated lookup gives the same answer
    p_hold_without_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && $past(fetch_valid) && $stable(fetch_pc) && !$past(upd_valid))
        |-> ($stable(pred_hit) && $stable(next_pc)));

    // R10: no hit without a fetch request
    p_idle_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> !pred_hit);
endmodule

bind btb_pred btb_pred_chk #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .next_pc     (next_pc),
    .pred_hit    (pred_hit),
    .upd_valid   (upd_valid)
);

// File: tb/btb_pred_bench.sv
module btb_pred_bench;
    import btb_pkg::*;

    localparam int PW    = 8;
    localparam int IW    = 3;
    localparam int DEPTH = 1 << IW;
    localparam int SPAN  = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [PW-1:0] fetch_pc = '0;
    logic          upd_valid = 1'b0;
    logic [PW-1:0] upd_pc = '0;
    logic [PW-1:0] upd_target = '0;
    logic          upd_taken = 1'b0;
    logic          upd_backward = 1'b0;
    logic [PW-1:0] next_l, next_b;
    logic          hit_l, hit_b;

    int checks = 0;
    int errors = 0;

    // Expected table contents per policy
    logic          lv [DEPTH];
    int            lt [DEPTH];
    int            lg [DEPTH];
    logic          bv [DEPTH];
    int            bt [DEPTH];
    int            bg [DEPTH];

    always #10 clk = ~clk;

    btb_pred #(.PC_W(PW), .IDX_W(IW), .POLICY(POL_LAST)) u_btb_pred (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .next_pc(next_l), .pred_hit(hit_l), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_target(upd_target), .upd_taken(upd_taken), .upd_backward(upd_backward)
    );

    btb_pred #(.PC_W(PW), .IDX_W(IW), .POLICY(POL_BACKWARD)) u_btb_pred_loop (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .next_pc(next_b), .pred_hit(hit_b), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_target(upd_target), .upd_taken(upd_taken), .upd_backward(upd_backward)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Check both instances for the current fetch_pc against the expected tables
    task automatic check_pc(input string phase, input int p);
        int  idx = p % DEPTH;
        int  tg  = p / DEPTH;
        int  seq = (p + 1) % SPAN;
        logic eh_l = fetch_valid && lv[idx] && (lt[idx] == tg);
        logic eh_b = fetch_valid && bv[idx] && (bt[idx] == tg);
        chk(eh_l ? "R3" : "R2", {phase, " last hit"}, int'(hit_l), int'(eh_l));
        chk(eh_l ? "R3" : "R2", {phase, " last next"}, int'(next_l), eh_l ? lg[idx] : seq);
        chk(eh_b ? "R3" : "R2", {phase, " loop hit"}, int'(hit_b), int'(eh_b));
        chk(eh_b ? "R3" : "R2", {phase, " loop next"}, int'(next_b), eh_b ? bg[idx] : seq);
    endtask

    task automatic sweep(input string phase);
        for (int p = 0; p < SPAN; p++) begin
            @(negedge clk);
            fetch_pc = PW'(p);
            #1;
            check_pc(phase, p);
        end
    endtask

    // Expected effect of one resolved branch, per the allocation rules
    task automatic model_update(input int pc, input int tgt, input logic tk, input logic bw);
        int idx = pc % DEPTH;
        int tg  = pc / DEPTH;
        if (tk) begin
            lv[idx] = 1'b1; lt[idx] = tg; lg[idx] = tgt;
        end else if (lv[idx] && lt[idx] == tg) begin
            lv[idx] = 1'b0;
        end
        if (tk && bw) begin
            bv[idx] = 1'b1; bt[idx] = tg; bg[idx] = tgt;
        end
    endtask

    task automatic do_update(input int pc, input int tgt, input logic tk, input logic bw);
        @(negedge clk);
        upd_pc = PW'(pc); upd_target = PW'(tgt);
        upd_taken = tk; upd_backward = bw; upd_valid = 1'b1;
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        model_update(pc, tgt, tk, bw);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            lv[i] = 1'b0; lt[i] = 0; lg[i] = 0;
            bv[i] = 1'b0; bt[i] = 0; bg[i] = 0;
        end
        repeat (3) @(negedge clk);
        fetch_valid = 1'b1;
        rst_n = 1'b1;

        // R1: empty table after reset, full sweep including wrap at the top address
        sweep("R1 after reset");

        // R4 and R6: taken backward installs in both; taken forward only in last-outcome
        do_update('h25, 'h10, 1'b1, 1'b1);
        do_update('h43, 'h80, 1'b1, 1'b0);
        sweep("R4 R6 installs");

        // R8 and R6: same index, new tag replaces in last-outcome; forward leaves loop table alone
        do_update('h2B, 'hC0, 1'b1, 1'b0);
        sweep("R8 R6 replace");

        // R5 and R7: not-taken clears on matching tag only; loop table untouched
        do_update('h25, 'h10, 1'b0, 1'b1);
        do_update('h4B, 'h11, 1'b0, 1'b0);
        sweep("R5 R7 not-taken");

        // R8: aliasing addresses on one index, the later install wins
        do_update('h9D, 'h90, 1'b1, 1'b1);
        do_update('h15, 'h05, 1'b1, 1'b1);
        sweep("R8 alias");

        // R10: a stored entry is not reported without a fetch request
        @(negedge clk);
        fetch_valid = 1'b0;
        fetch_pc = 8'h15;
        #1;
        chk("R10", "idle last hit", int'(hit_l), 0);
        chk("R10", "idle last next", int'(next_l), 'h16);
        chk("R10", "idle loop hit", int'(hit_b), 0);
        chk("R10", "idle loop next", int'(next_b), 'h16);
        @(negedge clk);
        fetch_valid = 1'b1;
        #1;
        chk("R10", "request last hit", int'(hit_l), 1);
        chk("R10", "request loop next", int'(next_b), 'h05);

        // R9: lookup and write to the same index in one cycle
        @(negedge clk);
        fetch_pc = 8'h66;
        upd_pc = 8'h66; upd_target = 8'h60;
        upd_taken = 1'b1; upd_backward = 1'b1; upd_valid = 1'b1;
        #1;
        chk("R9", "same-cycle last hit", int'(hit_l), 0);
        chk("R9", "same-cycle loop next", int'(next_b), 'h67);
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        model_update('h66, 'h60, 1'b1, 1'b1);
        chk("R9", "next-cycle last hit", int'(hit_l), 1);
        chk("R9", "next-cycle last next", int'(next_l), 'h60);
        chk("R9", "next-cycle loop hit", int'(hit_b), 1);
        sweep("R9 final");

        finish_run();
    end
endmodule